// File: doc/BRIEF.md
# Interrupt Message Vector Controller

This block turns interrupt requests from device logic into memory-write messages for a bus master. Each vector has a table entry with a 64-bit target address, a 32-bit payload and a mask bit. Software reaches the entry table, a read-only pending bitmap and a small control word through a word-wide register port. Requests are not lost while a vector is masked. The block records them in the pending bitmap and sends them on its own once the vector becomes unmasked.

Every vector is masked when its own mask bit is set or when the whole function is masked. The function is masked while the enable bit is clear or the mask-all bit is set. When the function mask is lifted, a scanner walks all vectors, one per clock, and sends every pending vector that is now unmasked, lowest index first. While the scanner runs, incoming requests are held off. Device logic must also declare which vectors it uses through per-vector use counters. Requests for a vector whose counter is zero are discarded. A control write that leaves the block enabled produces a one-cycle pulse that clears the legacy wire interrupt.

Top module: `msgvec_ctrl`

## Requirements
- R1: After reset the control word reads with enable and mask-all clear, every table word reads zero except the mask bit of every vector, which reads 1, both pending words read zero, and no message is valid.
- R2: The control word (region 0) reads enable at bit 15, mask-all at bit 14 and NUM_VEC-1 in bits [10:0]. Only bits 15 and 14 are writable.
- R3: Table region (1) word index 4*v+w selects, for vector v: w=0 address low, w=1 address high, w=2 payload, w=3 mask at bit 0 with the other bits reading 0. Accesses to a vector index at or above NUM_VEC read 0 and are ignored on write.
- R4: Pending region (2) word k, bit b shows vector 32*k+b, so vector v sits at byte v/8, bit v mod 8 in little-endian order. There are ceil(NUM_VEC/64)*2 words, and higher words read 0. Writes to this region change nothing.
- R5: A request for an in-use, unmasked vector produces one message carrying the vector index and that vector's table address and payload. The message stays valid and unchanged until msg_ready.
- R6: A request for an in-use vector that is masked, either by its own bit or by the function mask, sets its pending bit and sends no message.
- R7: When a vector goes from masked to unmasked while its pending bit is set, the block clears the bit and sends that vector's message. This applies to a per-vector mask write and to a control write that lifts the function mask. Several vectors are sent in ascending index order.
- R8: A request whose vector index is at or above NUM_VEC, or whose vector has a use count of zero, is accepted and discarded: no message and no pending bit.
- R9: A use request increments the vector's count, saturating at its maximum. A release decrements it. A release that brings the count to zero clears the pending bit. A release at count zero changes nothing.
- R10: One cycle after a control write with bit 15 set, intx_deassert is high for one cycle. It stays low after a control write with bit 15 clear.
- R11: At most one message is outstanding. irq_ready is low while a message waits or a function-unmask scan runs. The scan takes one clock per vector, plus any cycles it waits for a message to be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe, data one cycle later |
| reg_rgn | input | 2 | Region: 0 control, 1 table, 2 pending |
| reg_addr | input | REG_AW | 32-bit word index within the region |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_valid | input | 1 | Interrupt request valid |
| irq_vec | input | VIDX_W | Requested vector |
| irq_ready | output | 1 | Request accepted this cycle when high with irq_valid |
| use_valid | input | 1 | Use-counter operation valid |
| use_release | input | 1 | 0 increments, 1 decrements |
| use_vec | input | VIDX_W | Vector for the counter operation |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Bus master takes the message |
| msg_vec | output | VIDX_W | Vector of the message |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |
| intx_deassert | output | 1 | One-cycle pulse clearing the legacy wire interrupt |

## Verification
The assertions check the following on every cycle:
- a waiting message holds steady;
- a load never overwrites an outstanding message;
- a pending bit is only set for a masked vector;
- a replayed or released vector's pending bit is clear on the next cycle;
- a release at count zero leaves the counter at zero;
- requests are blocked while a scan runs;
- the wire-interrupt pulse follows each enabling control write.

Some properties span many cycles, and only the bench scenarios can show them. These are the ascending replay order across many vectors, the pending bitmap layout seen through register reads, the silent drop of unused or out-of-range vectors, and the mix of random masking, counting and requests checked against a reference model.

// File: rtl/msgvec_pkg.sv
package msgvec_pkg;

  typedef enum logic [1:0] {
    RGN_CTRL  = 2'd0,
    RGN_TABLE = 2'd1,
    RGN_PEND  = 2'd2,
    RGN_NONE  = 2'd3
  } rgn_e;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_VCTRL   = 2'd3
  } tword_e;

  localparam int CTRL_EN_BIT   = 15;
  localparam int CTRL_MALL_BIT = 14;
  localparam int SIZE_W        = 11;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msg_t;

  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // pending bitmap: vector count rounded up to 64, in 32-bit words
  function automatic int pend_words(int n);
    return ((n + 63) / 64) * 2;
  endfunction

  function automatic logic fn_masked(logic en, logic mall);
    return !en || mall;
  endfunction

endpackage

// File: rtl/msgvec_table.sv
module msgvec_table
  import msgvec_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int VW      = 3,
  parameter int REG_AW  = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_AW-1:0]  addr,
  input  logic [31:0]        wdata,
  input  logic               fn_mask,
  output logic [31:0]        rd_word,
  output logic [NUM_VEC-1:0] vmask,
  input  logic [VW-1:0]      lk_vec,
  output msg_t               lk_msg,
  output logic               unmask_evt
);

  localparam int TAW = REG_AW - 2;

  logic [TAW-1:0] row;
  tword_e         col;
  logic           row_ok;
  logic [VW-1:0]  rsel;

  logic [63:0] addr_q [NUM_VEC];
  logic [31:0] data_q [NUM_VEC];
  logic [NUM_VEC-1:0] mask_q;

  assign row    = addr[REG_AW-1:2];
  assign col    = tword_e'(addr[1:0]);
  assign row_ok = int'(row) < NUM_VEC;
  assign rsel   = row_ok ? row[VW-1:0] : '0;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && row_ok && (rsel == VW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        data_q[g] <= '0;
        mask_q[g] <= 1'b1;
      end else if (hit) begin
        case (col)
          W_ADDR_LO: addr_q[g][31:0]  <= wdata;
          W_ADDR_HI: addr_q[g][63:32] <= wdata;
          W_DATA:    data_q[g]        <= wdata;
          default:   mask_q[g]        <= wdata[0];
        endcase
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (row_ok) begin
      case (col)
        W_ADDR_LO: rd_word = addr_q[rsel][31:0];
        W_ADDR_HI: rd_word = addr_q[rsel][63:32];
        W_DATA:    rd_word = data_q[rsel];
        default:   rd_word = {31'd0, mask_q[rsel]};
      endcase
    end
  end

  // a vector mask bit clearing while the function is live ends a masked state
  assign unmask_evt = wr_en && row_ok && (col == W_VCTRL) && mask_q[rsel]
                      && !wdata[0] && !fn_mask;

  assign vmask       = mask_q;
  assign lk_msg.addr = addr_q[lk_vec];
  assign lk_msg.data = data_q[lk_vec];

endmodule

// File: rtl/msgvec_pend.sv
module msgvec_pend #(
  parameter int NUM_VEC = 8,
  parameter int VW      = 3,
  parameter int VIDX_W  = 12,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [VW-1:0]      set_vec,
  input  logic               clr_en,
  input  logic [VW-1:0]      clr_vec,
  input  logic               use_valid,
  input  logic               use_release,
  input  logic [VIDX_W-1:0]  use_vec,
  output logic [NUM_VEC-1:0] pend,
  output logic [NUM_VEC-1:0] in_use
);

  logic          use_ok;
  logic [VW-1:0] uv;
  logic [NUM_VEC-1:0] rel_clr;

  assign use_ok = int'(use_vec) < NUM_VEC;
  assign uv     = use_ok ? use_vec[VW-1:0] : '0;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             pend_q;

    assign hit        = use_valid && use_ok && (uv == VW'(g));
    assign rel_clr[g] = hit && use_release && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (hit) begin
        if (!use_release && (cnt_q != '1))
          cnt_q <= cnt_q + CNT_W'(1);
        else if (use_release && (cnt_q != '0))
          cnt_q <= cnt_q - CNT_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
      end else begin
        if (set_en && (set_vec == VW'(g))) pend_q <= 1'b1;
        if (clr_en && (clr_vec == VW'(g))) pend_q <= 1'b0;
        if (rel_clr[g])                    pend_q <= 1'b0;
      end
    end

    assign pend[g]   = pend_q;
    assign in_use[g] = cnt_q != '0;

    AST_REL_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rel_clr[g] |=> !pend_q);  // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && use_release && cnt_q == '0) |=> cnt_q == '0);  // R9
  end

endmodule

// File: rtl/msgvec_sched.sv
module msgvec_sched
  import msgvec_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int VW      = 3,
  parameter int VIDX_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_valid,
  input  logic [VIDX_W-1:0]  irq_vec,
  output logic               irq_ready,
  input  logic [NUM_VEC-1:0] in_use,
  input  logic [NUM_VEC-1:0] eff_mask,
  input  logic [NUM_VEC-1:0] pend,
  input  logic               start_scan,
  output logic [VW-1:0]      lk_vec,
  input  msg_t               lk_msg,
  output logic               set_en,
  output logic [VW-1:0]      set_vec,
  output logic               clr_en,
  output logic [VW-1:0]      clr_vec,
  output logic               scan_active,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [VIDX_W-1:0]  msg_vec,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);

  localparam logic [VW-1:0] LAST = VW'(NUM_VEC - 1);

  logic          scan_q;
  logic [VW-1:0] ptr_q;
  logic          mv_q;
  logic [VIDX_W-1:0] mvec_q;
  msg_t          mbody_q;

  logic          irq_ok, acc, drop, irq_pend, irq_fire;
  logic [VW-1:0] iv;
  logic          scan_hit, scan_fire, scan_adv, msg_load;

  assign irq_ok    = int'(irq_vec) < NUM_VEC;
  assign iv        = irq_ok ? irq_vec[VW-1:0] : '0;
  assign irq_ready = !scan_q && !mv_q;
  assign acc       = irq_valid && irq_ready;
  assign drop      = acc && (!irq_ok || !in_use[iv]);
  assign irq_pend  = acc && !drop && eff_mask[iv];
  assign irq_fire  = acc && !drop && !eff_mask[iv];

  assign scan_hit  = scan_q && pend[ptr_q] && !eff_mask[ptr_q];
  assign scan_fire = scan_hit && !mv_q;
  assign scan_adv  = scan_q && (!scan_hit || scan_fire);
  assign msg_load  = irq_fire || scan_fire;

  assign lk_vec  = scan_q ? ptr_q : iv;
  assign set_en  = irq_pend;
  assign set_vec = iv;
  assign clr_en  = scan_fire;
  assign clr_vec = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_q <= 1'b0;
      ptr_q  <= '0;
    end else if (start_scan) begin
      scan_q <= 1'b1;
      ptr_q  <= '0;
    end else if (scan_adv) begin
      if (ptr_q == LAST) scan_q <= 1'b0;
      else               ptr_q  <= ptr_q + VW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mv_q    <= 1'b0;
      mvec_q  <= '0;
      mbody_q <= '0;
    end else if (msg_load) begin
      mv_q    <= 1'b1;
      mvec_q  <= VIDX_W'(lk_vec);
      mbody_q <= lk_msg;
    end else if (mv_q && msg_ready) begin
      mv_q <= 1'b0;
    end
  end

  assign scan_active = scan_q;
  assign msg_valid   = mv_q;
  assign msg_vec     = mvec_q;
  assign msg_addr    = mbody_q.addr;
  assign msg_data    = mbody_q.data;

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vec)
                                   && $stable(msg_addr) && $stable(msg_data)));  // R5
  AST_SINGLE_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    msg_load |-> !msg_valid);  // R11
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !msg_valid);  // R8

endmodule

// File: rtl/msgvec_ctrl.sv
module msgvec_ctrl
  import msgvec_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int REG_AW  = 13,
  parameter int VIDX_W  = 12,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_rgn,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              irq_valid,
  input  logic [VIDX_W-1:0] irq_vec,
  output logic              irq_ready,
  input  logic              use_valid,
  input  logic              use_release,
  input  logic [VIDX_W-1:0] use_vec,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [VIDX_W-1:0] msg_vec,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data,
  output logic              intx_deassert
);

  localparam int VW = idx_width(NUM_VEC);
  localparam int PW = pend_words(NUM_VEC);

  rgn_e rgn;
  logic ctrl_wr, tbl_wr;
  logic en_q, mall_q, fn_mask, new_en, new_mall, ctrl_unmask;
  logic intx_q;
  logic [31:0] rdata_q, tbl_word, pend_word, ctrl_word, rd_mux;
  logic [NUM_VEC-1:0] vmask, eff_mask, pend, in_use;
  logic [VW-1:0] lk_vec, set_vec, clr_vec;
  msg_t lk_msg;
  logic tbl_unmask, set_en, clr_en, scan_active, pw_ok;

  assign rgn      = rgn_e'(reg_rgn);
  assign ctrl_wr  = reg_wr && (rgn == RGN_CTRL);
  assign tbl_wr   = reg_wr && (rgn == RGN_TABLE);
  assign fn_mask  = fn_masked(en_q, mall_q);
  assign new_en   = reg_wdata[CTRL_EN_BIT];
  assign new_mall = reg_wdata[CTRL_MALL_BIT];
  assign ctrl_unmask = ctrl_wr && fn_mask && !fn_masked(new_en, new_mall);
  assign eff_mask = vmask | {NUM_VEC{fn_mask}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mall_q <= 1'b0;
      intx_q <= 1'b0;
    end else begin
      intx_q <= ctrl_wr && new_en;
      if (ctrl_wr) begin
        en_q   <= new_en;
        mall_q <= new_mall;
      end
    end
  end

  msgvec_table #(.NUM_VEC(NUM_VEC), .VW(VW), .REG_AW(REG_AW)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr), .addr(reg_addr), .wdata(reg_wdata),
    .fn_mask(fn_mask), .rd_word(tbl_word), .vmask(vmask), .lk_vec(lk_vec),
    .lk_msg(lk_msg), .unmask_evt(tbl_unmask)
  );

  msgvec_pend #(.NUM_VEC(NUM_VEC), .VW(VW), .VIDX_W(VIDX_W), .CNT_W(CNT_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_vec(set_vec),
    .clr_en(clr_en), .clr_vec(clr_vec), .use_valid(use_valid),
    .use_release(use_release), .use_vec(use_vec), .pend(pend), .in_use(in_use)
  );

  msgvec_sched #(.NUM_VEC(NUM_VEC), .VW(VW), .VIDX_W(VIDX_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .irq_ready(irq_ready), .in_use(in_use), .eff_mask(eff_mask), .pend(pend),
    .start_scan(ctrl_unmask || tbl_unmask), .lk_vec(lk_vec), .lk_msg(lk_msg),
    .set_en(set_en), .set_vec(set_vec), .clr_en(clr_en), .clr_vec(clr_vec),
    .scan_active(scan_active), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vec(msg_vec), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  // pending bitmap word view: word k bit b is vector 32*k+b
  assign pw_ok = int'(reg_addr) < PW;
  always_comb begin
    pend_word = '0;
    for (int b = 0; b < 32; b++) begin
      int idx;
      idx = int'(reg_addr) * 32 + b;
      if (pw_ok && idx < NUM_VEC) pend_word[b] = pend[idx[VW-1:0]];
    end
  end

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_EN_BIT]   = en_q;
    ctrl_word[CTRL_MALL_BIT] = mall_q;
    ctrl_word[SIZE_W-1:0]    = SIZE_W'(NUM_VEC - 1);
  end

  always_comb begin
    case (rgn)
      RGN_CTRL:  rd_mux = ctrl_word;
      RGN_TABLE: rd_mux = tbl_word;
      RGN_PEND:  rd_mux = pend_word;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata     = rdata_q;
  assign intx_deassert = intx_q;

  AST_PEND_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> eff_mask[set_vec]);  // R6
  AST_REPLAY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !pend[$past(clr_vec)]);  // R7
  AST_INTX_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && new_en) |=> intx_deassert);  // R10
  AST_NO_INTX_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !new_en) |=> !intx_deassert);  // R10
  AST_SCAN_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    scan_active |-> !irq_ready);  // R11

endmodule

// File: tb/msgvec_ctrl_tb.sv
module msgvec_ctrl_tb;

  localparam int N      = 40;
  localparam int REG_AW = 13;
  localparam int VIDX_W = 12;
  localparam int CNT_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_rgn = 0;
  logic [REG_AW-1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq_valid = 0, irq_ready;
  logic [VIDX_W-1:0] irq_vec = 0;
  logic use_valid = 0, use_release = 0;
  logic [VIDX_W-1:0] use_vec = 0;
  logic msg_valid, msg_ready = 0;
  logic [VIDX_W-1:0] msg_vec;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic intx_deassert;

  always #2.5 clk = ~clk;

  msgvec_ctrl #(.NUM_VEC(N), .REG_AW(REG_AW), .VIDX_W(VIDX_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rgn(reg_rgn),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_ready(irq_ready),
    .use_valid(use_valid), .use_release(use_release), .use_vec(use_vec),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vec(msg_vec),
    .msg_addr(msg_addr), .msg_data(msg_data), .intx_deassert(intx_deassert)
  );

  int checks = 0, errors = 0;

  // reference model
  logic [63:0] m_addr [N];
  logic [31:0] m_data [N];
  bit m_mask [N];
  bit m_pend [N];
  int m_cnt [N];
  bit m_en, m_mall;

  function automatic bit exp_masked(int v);
    return !m_en || m_mall || m_mask[v];
  endfunction

  function automatic logic [31:0] exp_pend_word(int k);
    logic [31:0] w = '0;
    for (int b = 0; b < 32; b++)
      if (k * 32 + b < N && k < ((N + 63) / 64) * 2) w[b] = m_pend[k * 32 + b];
    return w;
  endfunction

  function automatic logic [31:0] exp_ctrl();
    return (32'(m_en) << 15) | (32'(m_mall) << 14) | 32'(N - 1);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(int rgn, int addr, logic [31:0] d);
    reg_wr = 1; reg_rgn = 2'(rgn); reg_addr = REG_AW'(addr); reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic reg_read(int rgn, int addr, output logic [31:0] d);
    reg_rd = 1; reg_rgn = 2'(rgn); reg_addr = REG_AW'(addr);
    tick();
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic do_ctrl(bit en, bit mall);
    reg_write(0, 0, 32'h0000_3F00 | (32'(en) << 15) | (32'(mall) << 14) | 32'h7FF);
    chk("R10 intx pulse", 64'(intx_deassert), 64'(en));
    m_en = en; m_mall = mall;
  endtask

  task automatic do_tbl(int v, int w, logic [31:0] d);
    reg_write(1, v * 4 + w, d);
    if (v < N) begin
      case (w)
        0: m_addr[v][31:0] = d;
        1: m_addr[v][63:32] = d;
        2: m_data[v] = d;
        default: m_mask[v] = d[0];
      endcase
    end
  endtask

  task automatic do_use(bit rel, int v);
    use_valid = 1; use_release = rel; use_vec = VIDX_W'(v);
    tick();
    use_valid = 0;
    if (v < N) begin
      if (!rel && m_cnt[v] < (1 << CNT_W) - 1) m_cnt[v]++;
      else if (rel && m_cnt[v] > 0) begin
        m_cnt[v]--;
        if (m_cnt[v] == 0) m_pend[v] = 0;
      end
    end
  endtask

  task automatic expect_msg(int v, string tag);
    int w = 0;
    while (!msg_valid && w < 4 * N + 8) begin tick(); w++; end
    chk({tag, " msg valid"}, 64'(msg_valid), 64'd1);
    if (msg_valid) begin
      chk({tag, " msg vec"}, 64'(msg_vec), 64'(v));
      chk({tag, " msg addr"}, msg_addr, m_addr[v]);
      chk({tag, " msg data"}, 64'(msg_data), 64'(m_data[v]));
      msg_ready = 1;
      tick();
      msg_ready = 0;
    end
  endtask

  task automatic expect_quiet(int cyc, string tag);
    bit seen = 0;
    for (int i = 0; i < cyc; i++) begin
      if (msg_valid) seen = 1;
      tick();
    end
    chk({tag, " no message"}, 64'(seen), 64'd0);
  endtask

  // returns 1 if the request should produce a message
  task automatic do_irq(int v, output bit fire);
    fire = 0;
    irq_valid = 1; irq_vec = VIDX_W'(v);
    while (!irq_ready) tick();
    tick();
    irq_valid = 0;
    if (v < N && m_cnt[v] > 0) begin
      if (exp_masked(v)) m_pend[v] = 1;
      else fire = 1;
    end
  endtask

  // expected replays, ascending, then a quiet window
  task automatic drain(string tag);
    for (int v = 0; v < N; v++)
      if (m_pend[v] && !exp_masked(v)) begin
        expect_msg(v, tag);
        m_pend[v] = 0;
      end
    expect_quiet(N + 4, tag);
  endtask

  task automatic check_pend(string tag);
    logic [31:0] d;
    for (int k = 0; k < 3; k++) begin
      reg_read(2, k, d);
      chk(tag, 64'(d), 64'(exp_pend_word(k)));
    end
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    bit f;
    void'($urandom(32'd7321));
    for (int v = 0; v < N; v++) begin
      m_addr[v] = '0; m_data[v] = '0; m_mask[v] = 1; m_pend[v] = 0; m_cnt[v] = 0;
    end
    m_en = 0; m_mall = 0;
    repeat (5) tick();
    rst_n = 1;
    tick();

    // R1 reset state
    chk("R1 msg_valid", 64'(msg_valid), 64'd0);
    reg_read(0, 0, d); chk("R1 ctrl", 64'(d), 64'(exp_ctrl()));
    reg_read(1, 3, d); chk("R1 mask v0", 64'(d), 64'd1);
    reg_read(1, (N - 1) * 4 + 3, d); chk("R1 mask last", 64'(d), 64'd1);
    reg_read(1, 0, d); chk("R1 addr v0", 64'(d), 64'd0);
    check_pend("R1 pending");

    // R2 control bits
    do_ctrl(1, 1);
    reg_read(0, 0, d); chk("R2 ctrl set", 64'(d), 64'(32'h0000_C000 | 32'(N - 1)));
    do_ctrl(0, 0);
    reg_read(0, 0, d); chk("R2 ctrl clr", 64'(d), 64'(32'(N - 1)));

    // R3 table layout
    for (int v = 0; v < N; v++) begin
      do_tbl(v, 0, $urandom); do_tbl(v, 1, $urandom); do_tbl(v, 2, $urandom);
    end
    reg_read(1, 1, d); chk("R3 addr hi v0", 64'(d), 64'(m_addr[0][63:32]));
    reg_read(1, (N - 1) * 4 + 2, d); chk("R3 data last", 64'(d), 64'(m_data[N - 1]));
    do_tbl(N - 1, 3, 32'hFFFF_FFFE);
    reg_read(1, (N - 1) * 4 + 3, d); chk("R3 mask clr", 64'(d), 64'd0);
    do_tbl(N - 1, 3, 32'hFFFF_FFFF);
    reg_read(1, (N - 1) * 4 + 3, d); chk("R3 mask only bit0", 64'(d), 64'd1);
    do_tbl(N, 0, 32'hDEAD_BEEF);
    reg_read(1, N * 4, d); chk("R3 out of range", 64'(d), 64'd0);

    // R6 / R4: masked request latches, bitmap position, writes ignored
    for (int v = 0; v < N; v++) do_use(0, v);
    do_ctrl(1, 0);
    do_irq(35, f);
    chk("R6 masked no fire", 64'(f), 64'd0);
    expect_quiet(6, "R6");
    reg_read(2, 1, d); chk("R4 v35 word1 bit3", 64'(d), 64'h8);
    reg_write(2, 1, 32'h0); reg_write(2, 0, 32'hFFFF_FFFF);
    check_pend("R4 write ignored");

    // R7 per-vector unmask replays
    do_tbl(35, 3, 0);
    drain("R7 vector unmask");
    check_pend("R7 pending cleared");

    // R5 direct message held until taken; R11 one outstanding
    do_irq(35, f);
    chk("R5 fire", 64'(f), 64'd1);
    repeat (3) tick();
    chk("R5 held", 64'(msg_valid), 64'd1);
    chk("R11 ready low while waiting", 64'(irq_ready), 64'd0);
    expect_msg(35, "R5");
    drain("R5");

    // R7 function unmask replays ascending; R11 scan blocks requests
    do_tbl(5, 3, 0); do_tbl(6, 3, 0);
    do_ctrl(1, 1);
    do_irq(6, f); do_irq(5, f);
    check_pend("R6 function masked");
    do_ctrl(1, 0);
    chk("R11 ready low in scan", 64'(irq_ready), 64'd0);
    drain("R7 function unmask");

    // R8 drops
    do_irq(N, f); do_irq(4095, f);
    do_use(1, 6);
    do_irq(6, f);
    chk("R8 drop", 64'(f), 64'd0);
    expect_quiet(8, "R8");
    check_pend("R8 nothing latched");

    // R9 counters
    do_irq(2, f);
    check_pend("R9 pend set");
    do_use(1, 2);
    check_pend("R9 release clears");
    do_use(1, 2); do_use(0, 2); do_use(1, 2);
    do_tbl(2, 3, 0);
    do_irq(2, f);
    expect_quiet(N + 4, "R9 no wrap");
    check_pend("R9 final");

    // random mix
    for (int it = 0; it < 120; it++) begin
      int op = $urandom_range(0, 9);
      int v = $urandom_range(0, N + 1);
      case (op)
        0, 1, 2, 3: begin
          do_irq(v, f);
          if (f) expect_msg(v, "R5 random");
        end
        4: do_tbl(v, 3, $urandom);
        5: do_ctrl(1'($urandom), 1'($urandom));
        6: do_use(1'($urandom), v);
        7: do_tbl(v, $urandom_range(0, 2), $urandom);
        8: reg_write(2, $urandom_range(0, 2), $urandom);
        default: begin
          check_pend("R4 random");
          reg_read(0, 0, d); chk("R2 random", 64'(d), 64'(exp_ctrl()));
        end
      endcase
      drain("R7 random");
    end
    check_pend("R4 end");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule